// File: doc/BRIEF.md
# Sequential Instruction-Miss Prefetch Generator

This block sits in front of the stride-training path of a shared second-level cache prefetcher. That cache sees misses from both the instruction and the data first-level caches. Each miss is offered on a valid/ready input. When tagged instruction prefetching is enabled and the miss is an instruction fetch, the block does not train the stride path with it. Instead it turns the miss into a short run of sequential block-ahead prefetch addresses, issued one per handshake on a valid/ready output. Every other miss is passed straight through to the stride path together with its requester context.

The run length (degree) and the page-stop option are taken from configuration inputs when the miss is accepted. When page stop is on, a candidate that leaves the page of the miss, or that wraps past the top of the address space, ends the run. The candidates that were never issued are added to a saturating drop counter. Each issued prefetch carries a fixed latency tag set by a parameter. The enable option is a register that comes out of reset set. A one-cycle write strobe changes it.

Top module: `ifetch_seq_prefetch`

## Requirements
- R1: After reset the enable register is 1, `drop_count` is 0 and `pf_valid` is 0. A write on `cfg_en_wr` takes effect from the next cycle. A miss accepted in the same cycle as the write is steered by the old value.
- R2: A miss with `miss_ifetch`=1 that is accepted while enabled is never presented on the stride path (`st_valid` stays 0 for it). It starts a prefetch run instead.
- R3: A run issues base + d*BLK_BYTES for d = 1, 2, … up to the degree, in increasing order of d, with one address per `pf_valid`&`pf_ready` cycle. The first address is valid in the cycle after the miss is accepted. While `pf_ready` is 0, `pf_valid` and `pf_addr` are held.
- R4: With page stop captured as 1, the first candidate whose address bits above log2(PAGE_BYTES) differ from those of the miss, or whose sum carries out of ADDR_W bits, is not issued, and the run ends in that cycle. No later candidate of that run is issued. `drop_count` then grows by degree − d + 1, where d is the index of that candidate. With page stop 0, addresses wrap modulo 2^ADDR_W and the run continues.
- R5: `pf_lat` equals the LATENCY parameter whenever `pf_valid` is 1.
- R6: While idle, a miss that is not an instruction fetch, or any miss while the enable register is 0, appears on `st_valid`/`st_addr` in the same cycle. In that case `miss_ready` follows `st_ready`.
- R7: While a run is in progress, `miss_ready` and `st_valid` are 0.
- R8: An instruction-fetch miss accepted with degree 0 issues no prefetch, and `miss_ready` is 1 again in the next cycle.
- R9: `st_ctx` carries `miss_ctx` unchanged. `miss_ctx` must be below MAX_CTX whenever `miss_valid` is 1.
- R10: `drop_count` saturates at all ones and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en_wr | input | 1 | Write strobe for the tagged-prefetch enable register |
| cfg_en_val | input | 1 | Value written to the enable register |
| cfg_page_stop | input | 1 | Page-stop option, sampled when a miss is accepted |
| cfg_degree | input | DEG_W | Run length, sampled when a miss is accepted |
| miss_valid | input | 1 | Miss offered |
| miss_ready | output | 1 | Miss accepted this cycle when high with `miss_valid` |
| miss_addr | input | ADDR_W | Miss address |
| miss_ifetch | input | 1 | Miss came from an instruction fetch |
| miss_ctx | input | CTX_W | Requester context |
| pf_valid | output | 1 | Prefetch address offered |
| pf_ready | input | 1 | Prefetch consumer ready |
| pf_addr | output | ADDR_W | Prefetch address |
| pf_lat | output | LAT_W | Latency tag of the prefetch |
| st_valid | output | 1 | Miss forwarded to the stride path |
| st_ready | input | 1 | Stride path ready |
| st_addr | output | ADDR_W | Forwarded miss address |
| st_ctx | output | CTX_W | Forwarded requester context |
| drop_count | output | CNT_W | Saturating count of candidates cut off by page stop |

## Verification
Two functions can fall in the same cycle: an enable-register write and the steering of a miss. The bench writes 0 to the enable register in the very cycle an instruction-fetch miss is accepted. It expects the run to start anyway, and the next instruction-fetch miss to go to the stride path. A page-stop cut-off can also meet counter saturation on the same edge: repeated first-candidate crossings with degree 15 push the counter past its ceiling, and the bench expects it to hold at all ones. A behavioural model built from address lists judges every output on every cycle. `pf_ready` and `st_ready` are randomised throughout.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
   typedef enum logic {GEN_IDLE = 1'b0, GEN_RUN = 1'b1} gen_state_e;
endpackage

// File: rtl/ifp_steer.sv
module ifp_steer #(
   parameter int ADDR_W = 32,
   parameter int CTX_W  = 2
) (
   input  logic              gen_idle,
   input  logic              tag_en,
   input  logic              miss_valid,
   input  logic              miss_ifetch,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic [CTX_W-1:0]  miss_ctx,
   input  logic              st_ready,
   output logic              miss_ready,
   output logic              st_valid,
   output logic [ADDR_W-1:0] st_addr,
   output logic [CTX_W-1:0]  st_ctx,
   output logic              gen_start
);
   logic to_gen;

   always_comb begin
      to_gen     = tag_en & miss_ifetch;
      miss_ready = gen_idle & (to_gen | st_ready);
      st_valid   = gen_idle & miss_valid & ~to_gen;
      st_addr    = miss_addr;
      st_ctx     = miss_ctx;
      gen_start  = miss_valid & miss_ready & to_gen;
   end
endmodule

// File: rtl/ifp_seq_gen.sv
module ifp_seq_gen
   import ifp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BLK_BYTES  = 64,
   parameter int PAGE_BYTES = 4096,
   parameter int DEG_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DEG_W-1:0]  start_degree,
   input  logic              start_pstop,
   input  logic              pf_ready,
   output logic              idle,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   output logic              drop_valid,
   output logic [DEG_W:0]    drop_amt
);
   localparam int BLK_LG  = $clog2(BLK_BYTES);
   localparam int PAGE_LG = $clog2(PAGE_BYTES);

   gen_state_e        state_q;
   logic [ADDR_W-1:0] base_q;
   logic [DEG_W-1:0]  idx_q;
   logic [DEG_W-1:0]  deg_q;
   logic              pstop_q;
   logic [ADDR_W:0]   cand;
   logic              page_diff;
   logic              cut;

   assign cand = {1'b0, base_q} + ((ADDR_W+1)'(idx_q) << BLK_LG);

   generate
      if (PAGE_LG < ADDR_W) begin : g_page_cmp
         assign page_diff = cand[ADDR_W-1:PAGE_LG] != base_q[ADDR_W-1:PAGE_LG];
      end else begin : g_no_page
         assign page_diff = 1'b0;
      end
   endgenerate

   assign cut        = pstop_q & (cand[ADDR_W] | page_diff);
   assign idle       = (state_q == GEN_IDLE);
   assign pf_valid   = (state_q == GEN_RUN) & ~cut;
   assign pf_addr    = cand[ADDR_W-1:0];
   assign drop_valid = (state_q == GEN_RUN) & cut;
   assign drop_amt   = (DEG_W+1)'(deg_q) - (DEG_W+1)'(idx_q) + (DEG_W+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= GEN_IDLE;
         base_q  <= '0;
         idx_q   <= '0;
         deg_q   <= '0;
         pstop_q <= 1'b0;
      end else if (state_q == GEN_IDLE) begin
         if (start && start_degree != '0) begin
            state_q <= GEN_RUN;
            base_q  <= start_addr;
            idx_q   <= DEG_W'(1);
            deg_q   <= start_degree;
            pstop_q <= start_pstop;
         end
      end else if (cut) begin
         state_q <= GEN_IDLE;
      end else if (pf_ready) begin
         if (idx_q == deg_q) state_q <= GEN_IDLE;
         else                idx_q   <= idx_q + DEG_W'(1);
      end
   end

   assert_pf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

   assert_no_issue_after_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
      drop_valid |=> (!pf_valid && idle));
endmodule

// File: rtl/ifp_drop_ctr.sv
module ifp_drop_ctr #(
   parameter int CNT_W = 16,
   parameter int AMT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [AMT_W-1:0] add_amt,
   output logic [CNT_W-1:0] count
);
   localparam int SW = ((CNT_W > AMT_W) ? CNT_W : AMT_W) + 1;
   localparam logic [SW-1:0] LIMIT = SW'({CNT_W{1'b1}});

   logic [CNT_W-1:0] cnt_q;
   logic [SW-1:0]    wide;

   assign wide  = SW'(cnt_q) + SW'(add_amt);
   assign count = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (add_en) cnt_q <= (wide > LIMIT) ? {CNT_W{1'b1}} : wide[CNT_W-1:0];
   end

   assert_no_decrease_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/ifetch_seq_prefetch.sv
module ifetch_seq_prefetch #(
   parameter int ADDR_W     = 32,
   parameter int BLK_BYTES  = 64,
   parameter int PAGE_BYTES = 4096,
   parameter int DEG_W      = 4,
   parameter int CTX_W      = 2,
   parameter int MAX_CTX    = 4,
   parameter int LAT_W      = 8,
   parameter int LATENCY    = 1,
   parameter int CNT_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en_wr,
   input  logic              cfg_en_val,
   input  logic              cfg_page_stop,
   input  logic [DEG_W-1:0]  cfg_degree,
   input  logic              miss_valid,
   output logic              miss_ready,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic              miss_ifetch,
   input  logic [CTX_W-1:0]  miss_ctx,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr,
   output logic [LAT_W-1:0]  pf_lat,
   output logic              st_valid,
   input  logic              st_ready,
   output logic [ADDR_W-1:0] st_addr,
   output logic [CTX_W-1:0]  st_ctx,
   output logic [CNT_W-1:0]  drop_count
);
   localparam int BLK_LG = $clog2(BLK_BYTES);

   generate
      if ((1 << BLK_LG) != BLK_BYTES) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two");
      end
      if ((1 << $clog2(PAGE_BYTES)) != PAGE_BYTES || PAGE_BYTES < BLK_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two no smaller than BLK_BYTES");
      end
      if (DEG_W + BLK_LG > ADDR_W) begin : g_bad_deg
         $error("DEG_W + log2(BLK_BYTES) must fit in ADDR_W");
      end
      if (MAX_CTX > (1 << CTX_W) || MAX_CTX < 1) begin : g_bad_ctx
         $error("MAX_CTX must lie in 1 .. 2**CTX_W");
      end
   endgenerate

   logic           tag_en_q;
   logic           gen_idle;
   logic           gen_start;
   logic           drop_valid;
   logic [DEG_W:0] drop_amt;

   always_ff @(posedge clk) begin
      if (!rst_n)         tag_en_q <= 1'b1;
      else if (cfg_en_wr) tag_en_q <= cfg_en_val;
   end

   ifp_steer #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_steer (
      .gen_idle   (gen_idle),
      .tag_en     (tag_en_q),
      .miss_valid (miss_valid),
      .miss_ifetch(miss_ifetch),
      .miss_addr  (miss_addr),
      .miss_ctx   (miss_ctx),
      .st_ready   (st_ready),
      .miss_ready (miss_ready),
      .st_valid   (st_valid),
      .st_addr    (st_addr),
      .st_ctx     (st_ctx),
      .gen_start  (gen_start)
   );

   ifp_seq_gen #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .PAGE_BYTES(PAGE_BYTES),
                 .DEG_W(DEG_W)) u_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (gen_start),
      .start_addr  (miss_addr),
      .start_degree(cfg_degree),
      .start_pstop (cfg_page_stop),
      .pf_ready    (pf_ready),
      .idle        (gen_idle),
      .pf_valid    (pf_valid),
      .pf_addr     (pf_addr),
      .drop_valid  (drop_valid),
      .drop_amt    (drop_amt)
   );

   ifp_drop_ctr #(.CNT_W(CNT_W), .AMT_W(DEG_W+1)) u_drop (
      .clk    (clk),
      .rst_n  (rst_n),
      .add_en (drop_valid),
      .add_amt(drop_amt),
      .count  (drop_count)
   );

   assign pf_lat = LAT_W'(LATENCY);

   assert_ctx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |-> (32'(miss_ctx) < MAX_CTX));

   assert_busy_blocks_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_idle |-> (!miss_ready && !st_valid));

   assert_ifetch_not_trained_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gen_start |-> !st_valid);

   assert_start_leaves_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_start && cfg_degree != '0) |=> !gen_idle);
endmodule

// File: tb/test_ifetch_seq_prefetch.sv
`timescale 1ns/1ps
module test_ifetch_seq_prefetch;
   localparam int AW = 16, BLK = 16, PG = 256, DW = 4, CW = 2, LW = 8, LAT = 7, NW = 5;
   localparam int CMAX = 31;

   logic clk = 0, rst_n = 0;
   logic cfg_en_wr = 0, cfg_en_val = 0, cfg_page_stop = 0;
   logic [DW-1:0] cfg_degree = '0;
   logic miss_valid = 0, miss_ifetch = 0;
   logic [AW-1:0] miss_addr = '0;
   logic [CW-1:0] miss_ctx = '0;
   logic pf_ready = 1, st_ready = 1;
   logic miss_ready, pf_valid, st_valid;
   logic [AW-1:0] pf_addr, st_addr;
   logic [LW-1:0] pf_lat;
   logic [CW-1:0] st_ctx;
   logic [NW-1:0] drop_count;

   int checks = 0, failures = 0, cyc = 0;
   bit rnd_ready = 0;

   // behavioural model
   int q[$];
   int drop_pend = 0;
   bit m_en = 1;
   int m_cnt = 0;

   always #10 clk = ~clk;

   ifetch_seq_prefetch #(.ADDR_W(AW), .BLK_BYTES(BLK), .PAGE_BYTES(PG), .DEG_W(DW),
      .CTX_W(CW), .MAX_CTX(4), .LAT_W(LW), .LATENCY(LAT), .CNT_W(NW)) i_ifetch_seq_prefetch (
      .clk(clk), .rst_n(rst_n), .cfg_en_wr(cfg_en_wr), .cfg_en_val(cfg_en_val),
      .cfg_page_stop(cfg_page_stop), .cfg_degree(cfg_degree),
      .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
      .miss_ifetch(miss_ifetch), .miss_ctx(miss_ctx),
      .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_lat(pf_lat),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_ctx(st_ctx),
      .drop_count(drop_count));

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
      end
   endtask

   function automatic bit m_busy();
      return (q.size() > 0) || (drop_pend > 0);
   endfunction

   function automatic bit m_route_gen();
      return m_en && miss_ifetch;
   endfunction

   // compare every cycle away from the edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (m_busy()) begin
            chk(miss_ready == 1'b0, "R7 miss_ready busy", miss_ready, 0);
            chk(st_valid == 1'b0, "R7 st_valid busy", st_valid, 0);
            chk(pf_valid == (q.size() > 0), "R3/R4 pf_valid", pf_valid, q.size() > 0);
            if (q.size() > 0) begin
               chk(pf_addr == AW'(q[0]), "R3 pf_addr", pf_addr, q[0]);
               chk(pf_lat == LW'(LAT), "R5 pf_lat", pf_lat, LAT);
            end
         end else begin
            chk(pf_valid == 1'b0, "R3 pf_valid idle", pf_valid, 0);
            chk(miss_ready == (m_route_gen() || st_ready), "R6 miss_ready", miss_ready,
                m_route_gen() || st_ready);
            chk(st_valid == (miss_valid && !m_route_gen()), "R2/R6 st_valid", st_valid,
                miss_valid && !m_route_gen());
            if (st_valid) begin
               chk(st_addr == miss_addr, "R6 st_addr", st_addr, miss_addr);
               chk(st_ctx == miss_ctx, "R9 st_ctx", st_ctx, miss_ctx);
            end
         end
         chk(drop_count == NW'(m_cnt), "R4/R10 drop_count", drop_count, m_cnt);
      end
   end

   // model update at the edge
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
      if (rst_n) begin
         if (m_busy()) begin
            if (q.size() > 0) begin
               if (pf_ready) void'(q.pop_front());
            end else begin
               m_cnt = (m_cnt + drop_pend > CMAX) ? CMAX : m_cnt + drop_pend;
               drop_pend = 0;
            end
         end else if (miss_valid && (m_route_gen() || st_ready) && m_route_gen()) begin
            int b;
            b = miss_addr;
            for (int d = 1; d <= cfg_degree; d++) begin
               int s;
               s = b + d * BLK;
               if (cfg_page_stop && (s >= (1 << AW) || (s / PG) != (b / PG))) begin
                  drop_pend = cfg_degree - d + 1;
                  break;
               end
               q.push_back(s % (1 << AW));
            end
         end
         if (cfg_en_wr) m_en = cfg_en_val;
      end
   end

   always @(posedge clk) begin
      #1;
      if (rnd_ready) begin
         pf_ready = 1'($urandom % 2);
         st_ready = 1'($urandom % 2);
      end else begin
         pf_ready = 1;
         st_ready = 1;
      end
   end

   task automatic send(input int addr, input bit ifetch, input int ctx, input int deg, input bit ps);
      bit acc;
      @(posedge clk); #2;
      miss_addr = AW'(addr); miss_ifetch = ifetch; miss_ctx = CW'(ctx);
      cfg_degree = DW'(deg); cfg_page_stop = ps; miss_valid = 1;
      forever begin
         @(negedge clk); acc = miss_ready;
         @(posedge clk); #2;
         if (acc) break;
      end
      miss_valid = 0;
   endtask

   task automatic drain();
      while (m_busy()) @(posedge clk);
      @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(drop_count == 0, "R1 reset drop_count", drop_count, 0);
      chk(pf_valid == 0, "R1 reset pf_valid", pf_valid, 0);
      chk(miss_ready == 1, "R1 reset miss_ready", miss_ready, 1);

      send('h1000, 1, 0, 4, 1); drain();          // R3 plain run
      rnd_ready = 1;
      send('h10C0, 1, 1, 6, 1); drain();          // R4 page cut at d=4, drop 3
      chk(drop_count == 3, "R4 drop after page cut", drop_count, 3);
      send('h10C0, 1, 1, 6, 0); drain();          // R4 page stop off continues
      send('hFFE0, 1, 2, 4, 1); drain();          // R4 wrap counts as crossing, drop 3
      chk(drop_count == 6, "R4 drop after wrap cut", drop_count, 6);
      send('hFFE0, 1, 2, 4, 0); drain();          // R4 wrap without page stop

      // R8 degree zero
      rnd_ready = 0;
      send('h2000, 1, 0, 0, 1);
      @(negedge clk);
      chk(miss_ready == 1, "R8 degree0 ready again", miss_ready, 1);
      chk(pf_valid == 0, "R8 degree0 no prefetch", pf_valid, 0);
      rnd_ready = 1;

      send('h3456, 0, 3, 5, 1); drain();          // R6, R9 data miss to stride path

      // R1 enable write in the same cycle as an ifetch miss
      drain();
      rnd_ready = 0;
      @(posedge clk); #2;
      miss_addr = 'h4000; miss_ifetch = 1; miss_ctx = 0; cfg_degree = 2; cfg_page_stop = 1;
      miss_valid = 1; cfg_en_wr = 1; cfg_en_val = 0;
      @(negedge clk);
      chk(st_valid == 0, "R1 old enable steers write-cycle miss", st_valid, 0);
      @(posedge clk); #2;
      miss_valid = 0; cfg_en_wr = 0;
      @(negedge clk);
      chk(pf_valid == 1 && pf_addr == 'h4010, "R1 run started", pf_addr, 'h4010);
      drain();
      send('h5000, 1, 1, 3, 1); drain();          // R6 disabled ifetch goes to stride
      @(posedge clk); #2 cfg_en_wr = 1; cfg_en_val = 1;
      @(posedge clk); #2 cfg_en_wr = 0;
      rnd_ready = 1;

      // R10 saturation: first candidate crosses, drop 15 each time
      send('h10F0, 1, 0, 15, 1); drain();
      chk(drop_count == 21, "R10 drop before saturation", drop_count, 21);
      send('h20F0, 1, 0, 15, 1); drain();
      chk(drop_count == 31, "R10 drop saturates", drop_count, 31);
      send('h30F0, 1, 0, 15, 1); drain();
      chk(drop_count == 31, "R10 drop holds at max", drop_count, 31);

      send('h0100, 1, 2, 15, 1); drain();         // R3 long run within page
      repeat (4) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule